// File: doc/BRIEF.md
# Shadow Boot ROM Overlay Controller

This block is glue logic on an 8-bit processor bus. It lays a small boot ROM over the memory map and removes it again by decoding bus cycles. After reset every memory read is served by the ROM. The startup code copies itself into RAM and then jumps into the upper half of memory. That opcode fetch takes the ROM out of the map, so RAM owns the whole address space.

A later opcode fetch from the non-maskable interrupt vector puts the ROM back. The interrupt handler therefore runs from ROM and not from the operating-system data kept in low RAM. Every ROM read is stretched by one wait state, and all other cycles run at full speed. The block also divides its source clock by two to make the processor clock and the inverse of that clock.

Overlay changes caused by a fetch are held back until the fetch cycle ends, so the fetch in progress always sees a stable memory map. All sequential logic runs on the source clock. It advances once per processor clock period, on the source edge where the processor clock rises.

Top module: `shadow_rom_ctl`

## Requirements
- R1: While reset is held, and after it is released, the overlay is active: a memory read (mreq_ni=0, rd_ni=0) gives rom_oe_no=0. While reset is held, cpu_clk_o=0.
- R2: rom_oe_no is 0 only during a memory read while the overlay is active. It stays 1 for memory writes (mreq_ni=0, rd_ni=1) and for non-memory cycles (mreq_ni=1).
- R3: An opcode fetch (m1_ni=0, mreq_ni=0) at an address with the top bit set (8000H or above) removes the overlay once that cycle ends.
- R4: A data read (m1_ni=1) at 8000H or above leaves the overlay unchanged.
- R5: An opcode fetch at the vector address NMI_VEC (default 0066H) makes the overlay active again once that cycle ends.
- R6: The overlay state does not change while mreq_ni is low. Every output decode inside one bus cycle uses the state from before that cycle.
- R7: wait_no is 0 from the start of a ROM read until the next rising edge of the processor clock, and is 1 from then until the access ends. This gives one wait state per access.
- R8: wait_no stays 1 on RAM reads, on writes and on non-memory cycles.
- R9: cpu_clk_o toggles on every rising edge of clk_i after reset, and cpu_clk_n_o is always its complement.
- R10: ram_cs_no is 0 for every memory cycle that is not a ROM read, including writes into the low addresses under an active overlay. It is 1 during ROM reads and non-memory cycles.
- R11: If both a vector fetch and an upper-half fetch are recorded within one bus cycle, the overlay is active after that cycle ends (set wins).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock, twice the processor clock rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Processor address bus |
| mreq_ni | input | 1 | Active-low memory request |
| rd_ni | input | 1 | Active-low read strobe |
| m1_ni | input | 1 | Active-low opcode-fetch strobe |
| cpu_clk_o | output | 1 | Processor clock, half the source rate |
| cpu_clk_n_o | output | 1 | Inverse phase of the processor clock |
| rom_oe_no | output | 1 | Active-low boot ROM output enable |
| ram_cs_no | output | 1 | Active-low RAM select |
| wait_no | output | 1 | Active-low wait request to the processor |

## Verification
The bench sweeps several hundred fetches, data reads and writes over addresses spread across the map. It tracks the expected overlay state arithmetically and checks each decode against it. The addresses include the vector, its neighbours and both sides of the 8000H boundary. A design that decodes the upper half as a plain address would drop the ROM on high data reads, and an off-by-one vector compare would miss the return to ROM. A design that applies changes immediately would switch the ROM enable in the middle of the triggering fetch. A wait generator that never releases, or that fires on RAM cycles, shows up as a wrong wait_no at the second sample of an access. One cycle that records both a set and a clear checks that set wins.

// File: rtl/srom_pkg.sv
package srom_pkg;

  typedef struct packed {
    logic set;
    logic clr;
  } ovl_evt_t;

  function automatic logic ovl_next(input ovl_evt_t ev, input logic cur);
    if (ev.set)      return 1'b1;
    else if (ev.clr) return 1'b0;
    else             return cur;
  endfunction

  function automatic logic evt_any(input ovl_evt_t ev);
    return ev.set | ev.clr;
  endfunction

endpackage

// File: rtl/srom_clkdiv.sv
module srom_clkdiv (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cpu_clk_o,
  output logic cpu_clk_n_o,
  output logic rise_en_o
);
  logic ph_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  assign cpu_clk_o   = ph_q;
  assign cpu_clk_n_o = ~ph_q;
  assign rise_en_o   = ~ph_q;

  AST_CLK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_q |=> ph_q);  // R9
  AST_CLK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q |=> !ph_q);  // R9
endmodule

// File: rtl/srom_overlay.sv
module srom_overlay
  import srom_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mreq_ni,
  input  logic              m1_ni,
  output logic              ovl_o,
  output ovl_evt_t          evt_o
);
  localparam int unsigned TOP_BIT = ADDR_W - 1;

  logic     fetch;
  logic     ovl_q;
  ovl_evt_t pend_q;

  assign fetch     = !mreq_ni && !m1_ni;
  assign evt_o.set = fetch && (addr_i == NMI_VEC);
  assign evt_o.clr = fetch && addr_i[TOP_BIT];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ovl_q  <= 1'b1;
      pend_q <= '0;
    end else if (en_i) begin
      if (!mreq_ni) begin
        pend_q <= pend_q | evt_o;
      end else begin
        if (evt_any(pend_q)) ovl_q <= ovl_next(pend_q, ovl_q);
        pend_q <= '0;
      end
    end
  end

  assign ovl_o = ovl_q;

  AST_HOLD_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_q != $past(ovl_q)) |-> ($past(mreq_ni) && $past(en_i)));  // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mreq_ni && pend_q.set) |=> ovl_q);  // R11
  AST_CLR_APPLIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mreq_ni && pend_q.clr && !pend_q.set) |=> !ovl_q);  // R3
  AST_DATA_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !mreq_ni && m1_ni) |=> (pend_q == $past(pend_q)));  // R4
endmodule

// File: rtl/srom_wait.sv
module srom_wait (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rom_rd_i,
  output logic wait_no
);
  logic done_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   done_q <= 1'b0;
    else if (en_i) done_q <= rom_rd_i;
  end

  assign wait_no = ~(rom_rd_i && !done_q);

  AST_ONE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rom_rd_i && !wait_no) |=> wait_no);  // R7
endmodule

// File: rtl/shadow_rom_ctl.sv
module shadow_rom_ctl
  import srom_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mreq_ni,
  input  logic              rd_ni,
  input  logic              m1_ni,
  output logic              cpu_clk_o,
  output logic              cpu_clk_n_o,
  output logic              rom_oe_no,
  output logic              ram_cs_no,
  output logic              wait_no
);
  logic     rise_en;
  logic     ovl;
  ovl_evt_t evt;
  logic     rom_rd;
  logic     mem_cyc;

  srom_clkdiv u_clkdiv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_clk_o  (cpu_clk_o),
    .cpu_clk_n_o(cpu_clk_n_o),
    .rise_en_o  (rise_en)
  );

  srom_overlay #(.ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC)) u_overlay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rise_en),
    .addr_i (addr_i),
    .mreq_ni(mreq_ni),
    .m1_ni  (m1_ni),
    .ovl_o  (ovl),
    .evt_o  (evt)
  );

  assign mem_cyc = !mreq_ni;
  assign rom_rd  = ovl && mem_cyc && !rd_ni;

  srom_wait u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rise_en),
    .rom_rd_i(rom_rd),
    .wait_no (wait_no)
  );

  assign rom_oe_no = ~rom_rd;
  assign ram_cs_no = ~(mem_cyc && !rom_rd);

  AST_WAIT_ONLY_ROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_no |-> !rom_oe_no);  // R8
  AST_RESET_OVERLAY: assert property (@(posedge clk_i)
    !rst_ni |=> ovl);  // R1
endmodule

// File: tb/test_shadow_rom_ctl.sv
module test_shadow_rom_ctl;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] addr_i;
  logic        mreq_ni, rd_ni, m1_ni;
  logic        cpu_clk_o, cpu_clk_n_o, rom_oe_no, ram_cs_no, wait_no;

  int vectors = 0;
  int fails   = 0;
  logic exp_ovl;
  logic prev_clk;
  logic [15:0] lcg;

  shadow_rom_ctl i_shadow_rom_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .mreq_ni(mreq_ni),
    .rd_ni(rd_ni), .m1_ni(m1_ni), .cpu_clk_o(cpu_clk_o),
    .cpu_clk_n_o(cpu_clk_n_o), .rom_oe_no(rom_oe_no),
    .ram_cs_no(ram_cs_no), .wait_no(wait_no)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic cpu_step();
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    #1;
  endtask

  task automatic bus_idle();
    mreq_ni = 1'b1; rd_ni = 1'b1; m1_ni = 1'b1;
  endtask

  // One bus access: fetch (m1), data read, or write, then idle to end the cycle.
  task automatic access(input logic [15:0] a, input logic fetch, input logic rd);
    logic rom;
    rom = exp_ovl && (rd || fetch);
    addr_i = a; mreq_ni = 1'b0; rd_ni = !(rd || fetch); m1_ni = !fetch;
    #1;
    chk(rd || fetch ? "R2 oe" : "R2 oe on write", rom_oe_no, !rom);
    chk("R10 ram select", ram_cs_no, rom);
    chk(rom ? "R7 wait asserted" : "R8 no wait", wait_no, !rom);
    cpu_step();
    chk("R7 wait released", wait_no, 1'b1);
    chk("R6 oe stable in cycle", rom_oe_no, !rom);
    bus_idle();
    cpu_step();
    if (fetch) begin
      if (a == 16'h0066) exp_ovl = 1'b1;      // R5
      else if (a[15])    exp_ovl = 1'b0;      // R3
    end                                        // R4: data reads never change it
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    addr_i = 16'h0000;
    bus_idle();
    exp_ovl = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1;
    chk("R1 clk low in reset", cpu_clk_o, 1'b0);
    mreq_ni = 1'b0; rd_ni = 1'b0; #1;
    chk("R1 rom in reset", rom_oe_no, 1'b0);
    bus_idle();
    rst_ni = 1'b1;
    cpu_step();

    // R9: clock divider phases
    prev_clk = cpu_clk_o;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i); #1;
      chk("R9 toggle", cpu_clk_o, !prev_clk);
      chk("R9 complement", cpu_clk_n_o, !cpu_clk_o);
      prev_clk = cpu_clk_o;
    end

    // R1: first read after reset comes from the ROM
    access(16'h0000, 1'b0, 1'b1);
    // R2/R10: write under overlay goes to RAM; I/O cycle touches neither
    access(16'h0010, 1'b0, 1'b0);
    mreq_ni = 1'b1; rd_ni = 1'b0; #1;
    chk("R2 io no oe", rom_oe_no, 1'b1);
    chk("R10 io no ram", ram_cs_no, 1'b1);
    chk("R8 io no wait", wait_no, 1'b1);
    bus_idle(); cpu_step();
    // R4: high data read keeps the ROM
    access(16'h8000, 1'b0, 1'b1);
    access(16'h0001, 1'b0, 1'b1);
    // R3: high fetch drops it; R6 checked inside the fetch itself
    access(16'h8000, 1'b1, 1'b1);
    access(16'h0000, 1'b0, 1'b1);
    // R5: vector neighbours do not restore, the vector does
    access(16'h0065, 1'b1, 1'b1);
    access(16'h0067, 1'b1, 1'b1);
    access(16'h0066, 1'b1, 1'b1);
    access(16'h0000, 1'b0, 1'b1);
    access(16'h7FFF, 1'b1, 1'b1);
    access(16'hFFFF, 1'b1, 1'b1);

    // R11: both events recorded within one cycle, in either order
    for (int k = 0; k < 2; k++) begin
      addr_i = k ? 16'h0066 : 16'hC000; mreq_ni = 1'b0; rd_ni = 1'b0; m1_ni = 1'b0;
      cpu_step();
      addr_i = k ? 16'hC000 : 16'h0066;
      cpu_step();
      bus_idle(); cpu_step();
      exp_ovl = 1'b1;
      mreq_ni = 1'b0; rd_ni = 1'b0; addr_i = 16'h0200; #1;
      chk("R11 set wins", rom_oe_no, 1'b0);
      bus_idle(); cpu_step();
      access(16'h9000, 1'b1, 1'b1);   // clear again for the next order
    end

    // Sweep: spread addresses, mixed cycle types
    lcg = 16'h1D2B;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      lcg = lcg * 16'd25173 + 16'd13849;
      case (lcg[2:0])
        3'd0:    a = 16'h0066;
        3'd1:    a = 16'h8000;
        3'd2:    a = 16'h7FFF;
        default: a = 16'(i * 257) ^ {lcg[15:8], 8'h00};
      endcase
      access(a, lcg[4], lcg[5] | lcg[4]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule